// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns pointer motion and button events into a stream of five-byte serial mouse packets. It stores the bytes in an on-chip byte queue, and a host reads that queue one byte at a time. Each accepted event produces one packet. The first byte of the packet is a sync byte, and its three low bits report the buttons, active low. The second and third bytes are the clamped horizontal and vertical deltas. Two zero motion bytes close the packet.

The producer side pulses `evtValid` for one cycle and holds the signed deltas and the button levels on the same cycle. The vertical delta is negated before it is encoded, so that upward motion reads as positive. The consumer side sees the byte at the head of the queue on `rdData`, with `rdValid` set. It pulses `rdAck` to take that byte. If the queue is empty, `rdData` keeps showing the last byte that was taken.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset the queue is empty, `rdValid` is 0 and `rdData` reads 0x00.
- R2: The first byte of a packet is 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared when the middle button is pressed and bit 0 cleared when the right button is pressed.
- R3: An event accepted at a clock edge pushes its five bytes on the next five edges, one per edge, in this order: start byte, X byte, Y byte, 0x00, 0x00.
- R4: The X byte is `dx` saturated to the range -127..+127 and written in 8-bit two's complement. For example, 128 becomes 0x7F and -128 becomes 0x81.
- R5: The Y byte is the negated `dy`, saturated to -127..+127 and written in two's complement. For example, `dy` = -512 becomes 0x7F.
- R6: An `evtValid` pulse that arrives while a packet is still being pushed is ignored. It adds no bytes to the queue.
- R7: The queue holds 256 bytes. A byte pushed while 256 bytes are stored is dropped, and the bytes already stored stay unchanged.
- R8: An `rdAck` while `rdValid` is 1 removes the head byte, and the next stored byte appears on the following cycle. Bytes come out in push order, including across pointer wrap.
- R9: An `rdAck` while the queue is empty changes nothing. `rdData` keeps the last byte taken, and later reads continue in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event strobe, one cycle |
| dx | input | DELTA_W | Signed horizontal delta |
| dy | input | DELTA_W | Signed vertical delta, positive downward |
| btnLeft | input | 1 | Left button pressed |
| btnMiddle | input | 1 | Middle button pressed |
| btnRight | input | 1 | Right button pressed |
| rdAck | input | 1 | Take the head byte |
| rdData | output | 8 | Head byte, or the last byte taken when empty |
| rdValid | output | 1 | Queue holds at least one byte |

## Verification
The assertions watch the following on every cycle:
- the occupancy bound;
- the one-byte decrement on a read;
- the frozen occupancy when a push meets a full queue;
- the stable output on an empty read;
- the start of a push run on the cycle after an event is accepted;
- that no event is accepted while a packet is being pushed.

Only the bench scenarios can show:
- the byte values: saturation at ±127, negation of Y and the inverted button bits, swept across the delta range and every button combination;
- the exact byte order;
- which bytes survive an overflow;
- in-order delivery across pointer wrap.

// File: rtl/mouse_pkt_pkg.sv
package mouse_pkt_pkg;
  localparam int PKT_LEN = 5;
  localparam int SEL_W = 3;
  localparam logic [7:0] SYNC_BYTE = 8'h87;

  typedef struct packed {
    logic capture;
    logic push;
    logic [SEL_W-1:0] sel;
  } strobe_t;
endpackage

// File: rtl/mouse_pkt_ctrl.sv
module mouse_pkt_ctrl
  import mouse_pkt_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic evtValid,
  output strobe_t st
);
  logic emitting;
  logic [SEL_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emitting <= 1'b0;
      idx <= '0;
    end else if (!emitting) begin
      if (evtValid) begin
        emitting <= 1'b1;
        idx <= '0;
      end
    end else begin
      if (idx == SEL_W'(PKT_LEN - 1)) emitting <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    st.capture = !emitting && evtValid;
    st.push = emitting;
    st.sel = idx;
  end
endmodule

// File: rtl/mouse_pkt_dp.sv
module mouse_pkt_dp
  import mouse_pkt_pkg::*;
#(
  parameter int DELTA_W = 10,
  parameter int DEPTH = 256
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t st,
  input  logic [DELTA_W-1:0] dx,
  input  logic [DELTA_W-1:0] dy,
  input  logic btnLeft,
  input  logic btnMiddle,
  input  logic btnRight,
  input  logic rdAck,
  output logic [7:0] rdData,
  output logic rdValid,
  output logic [$clog2(DEPTH):0] occupancy
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int EXT_W = DELTA_W + 1;
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'(127);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -POS_LIM;

  function automatic logic [7:0] sat(input logic signed [EXT_W-1:0] v);
    if (v > POS_LIM) return 8'h7f;
    else if (v < NEG_LIM) return 8'h81;
    else return v[7:0];
  endfunction

  logic signed [EXT_W-1:0] xExt, yNeg;
  logic [7:0] xByte, yByte, startByte, pushByte;
  logic [7:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [7:0] lastByte;
  logic doPush, doPop;

  assign xExt = EXT_W'($signed(dx));
  assign yNeg = -EXT_W'($signed(dy));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xByte <= '0;
      yByte <= '0;
      startByte <= SYNC_BYTE;
    end else if (st.capture) begin
      xByte <= sat(xExt);
      yByte <= sat(yNeg);
      startByte <= SYNC_BYTE & ~{5'b0, btnLeft, btnMiddle, btnRight};
    end
  end

  always_comb begin
    case (st.sel)
      SEL_W'(0): pushByte = startByte;
      SEL_W'(1): pushByte = xByte;
      SEL_W'(2): pushByte = yByte;
      default:   pushByte = 8'h00;
    endcase
  end

  assign doPush = st.push && (count != CNT_W'(DEPTH));
  assign doPop = rdAck && (count != '0);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      lastByte <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop) begin
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        lastByte <= mem[rdPtr];
      end
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  assign rdValid = count != '0;
  assign rdData = rdValid ? mem[rdPtr] : lastByte;
  assign occupancy = count;
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mouse_pkt_pkg::*;
#(
  parameter int DELTA_W = 10,
  parameter int DEPTH = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic evtValid,
  input  logic [DELTA_W-1:0] dx,
  input  logic [DELTA_W-1:0] dy,
  input  logic btnLeft,
  input  logic btnMiddle,
  input  logic btnRight,
  input  logic rdAck,
  output logic [7:0] rdData,
  output logic rdValid
);
  strobe_t st;
  logic [$clog2(DEPTH):0] occupancy;
  logic pushStb, capStb;

  assign pushStb = st.push;
  assign capStb = st.capture;

  mouse_pkt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .st(st)
  );

  mouse_pkt_dp #(.DELTA_W(DELTA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .dx(dx), .dy(dy),
    .btnLeft(btnLeft), .btnMiddle(btnMiddle), .btnRight(btnRight),
    .rdAck(rdAck), .rdData(rdData), .rdValid(rdValid), .occupancy(occupancy)
  );
endmodule

// File: rtl/mouse_pkt_chk.sv
module mouse_pkt_chk #(
  parameter int DEPTH = 256
) (
  input logic clk,
  input logic rstN,
  input logic rdAck,
  input logic rdValid,
  input logic [7:0] rdData,
  input logic [$clog2(DEPTH):0] occupancy,
  input logic pushStb,
  input logic capStb
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushStb && !rdAck && occupancy == CNT_W'(DEPTH) |=> occupancy == CNT_W'(DEPTH));

  // R8
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAck && rdValid && !pushStb |=> occupancy == $past(occupancy) - 1'b1);

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAck && !rdValid && !pushStb |=> $stable(rdData) && !rdValid);

  // R3
  push_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    capStb |=> pushStb);

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    capStb |-> !pushStb);
endmodule

bind mouse_pkt_enc mouse_pkt_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .rdAck(rdAck), .rdValid(rdValid), .rdData(rdData),
  .occupancy(occupancy), .pushStb(pushStb), .capStb(capStb)
);

// File: tb/mouse_pkt_enc_tb_top.sv
module mouse_pkt_enc_tb_top;
  localparam int DELTA_W = 10;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic [DELTA_W-1:0] dx = '0, dy = '0;
  logic btnLeft = 1'b0, btnMiddle = 1'b0, btnRight = 1'b0;
  logic rdAck = 1'b0;
  logic [7:0] rdData;
  logic rdValid;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] expQ [DEPTH];

  always #5 clk = ~clk;

  mouse_pkt_enc #(.DELTA_W(DELTA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .dx(dx), .dy(dy),
    .btnLeft(btnLeft), .btnMiddle(btnMiddle), .btnRight(btnRight),
    .rdAck(rdAck), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] satB(input int v);
    if (v > 127) return 8'h7f;
    if (v < -127) return 8'h81;
    return 8'(v);
  endfunction

  function automatic logic [7:0] expByte(input int x, input int y, input int b, input int i);
    case (i)
      0: return 8'h87 & ~8'(b);
      1: return satB(x);
      2: return satB(-y);
      default: return 8'h00;
    endcase
  endfunction

  // b: bit2 left, bit1 middle, bit0 right
  task automatic sendEvt(input int x, input int y, input int b, input int gap);
    @(negedge clk);
    dx = DELTA_W'(x); dy = DELTA_W'(y);
    {btnLeft, btnMiddle, btnRight} = 3'(b);
    evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic readByte(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk({req, " valid"}, 8'(rdValid), 8'h01);
    chk(req, rdData, exp);
    rdAck = 1'b1;
    @(negedge clk);
    rdAck = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    nChecks++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int cx[6] = '{127, 128, -127, -128, -512, 511};
    int cy[6] = '{-127, -128, 127, 128, -512, 511};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 8'(rdValid), 8'h00);
    chk("R1 data", rdData, 8'h00);

    // R2 R3 R4 R5 sweep of deltas, buttons and boundaries
    for (int i = 0; i < 100; i++) begin
      int x, y, b;
      x = (i < 6) ? cx[i] : (((i * 173) % 1024) - 512);
      y = (i < 6) ? cy[i] : (((i * 389) % 1024) - 512);
      b = i % 8;
      sendEvt(x, y, b, 6);
      for (int k = 0; k < 5; k++)
        readByte((k == 0) ? "R2 start" : (k == 1) ? "R4 x" : (k == 2) ? "R5 y" : "R3 tail",
                 expByte(x, y, b, k));
      @(negedge clk);
      chk("R3 len", 8'(rdValid), 8'h00);
    end

    // R6 event during emission ignored
    @(negedge clk);
    dx = DELTA_W'(5); dy = DELTA_W'(-6); {btnLeft, btnMiddle, btnRight} = 3'b100;
    evtValid = 1'b1;
    @(negedge clk);
    dx = DELTA_W'(90); dy = DELTA_W'(90); {btnLeft, btnMiddle, btnRight} = 3'b011;
    @(negedge clk);
    evtValid = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 5; k++) readByte("R6 first", expByte(5, -6, 4, k));
    @(negedge clk);
    chk("R6 no extra", 8'(rdValid), 8'h00);

    // R7 overflow: 52 packets = 260 pushes, 256 kept
    for (int p = 0; p < 52; p++) begin
      for (int k = 0; k < 5; k++)
        if (p * 5 + k < DEPTH) expQ[p * 5 + k] = expByte(p * 9 - 200, 150 - p * 7, p % 8, k);
      sendEvt(p * 9 - 200, 150 - p * 7, p % 8, 6);
    end
    // R8 in-order drain across wrap
    for (int j = 0; j < DEPTH; j++) readByte((j == DEPTH - 1) ? "R7 last kept" : "R8 order", expQ[j]);
    @(negedge clk);
    chk("R7 drop", 8'(rdValid), 8'h00);
    // R9 empty read
    chk("R9 last", rdData, expQ[DEPTH - 1]);
    rdAck = 1'b1;
    @(negedge clk);
    rdAck = 1'b0;
    @(negedge clk);
    chk("R9 still empty", 8'(rdValid), 8'h00);
    chk("R9 hold", rdData, expQ[DEPTH - 1]);
    sendEvt(-3, 40, 2, 6);
    for (int k = 0; k < 5; k++) readByte("R9 after", expByte(-3, 40, 2, k));

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule